// File: doc/BRIEF.md
# Epoch-Seconds Real-Time Clock Core

This core keeps wall time as an unsigned number of seconds. The number is the sum of a loadable base value and a free-running seconds counter. A one-cycle pulse on `tick`, arriving once per second, advances the counter. The current sum is always visible on `timeNow`. The host never touches the time registers directly. It places command bits on a control word, with any operand on the two write-data halves. The core acts on those commands only in the clock cycle in which the isolation-enable strobe `isoEn` is first seen high. That cycle is the "commit cycle" used throughout this brief.

The commands are:
- load the base;
- clear the counter;
- load either of two software flag words;
- return the base or a flag word on the read-data halves;
- arm a counter snapshot.

After a snapshot has been armed, a pulse on `snapTrig` copies the counter into the snapshot halves in one step. Setting the clock takes three steps: load the base, clear the counter, then write 1 into flag 0 so that later readers know the time is valid. All widths follow the parameter `WIDTH`, whose default is 32. Each data half is `WIDTH/2` bits wide.

Top module: `rtc_epoch_core`

## Requirements
- R1: After reset, `timeNow`, both read-data halves and both snapshot halves are zero, and both flag words read back as zero.
- R2: Outside a counter clear, each cycle with `tick` high adds one to the counter. The counter wraps from all-ones to zero, and `timeNow` = base + counter modulo 2^WIDTH.
- R3: Commands are taken only in a commit cycle, which is a cycle where `isoEn` is high after having been low in the previous cycle. Keeping `isoEn` high, or changing `ctrlWord` or the write data while it stays high, has no further effect.
- R4: Control bit 1 loads the base with {`wrDataHi`,`wrDataLo`}, so `timeNow` changes in the cycle after the commit.
- R5: Control bit 2 copies the base onto {`rdDataHi`,`rdDataLo`}. If a base load is committed in the same cycle, the read returns the base held before that load.
- R6: Control bit 3 clears the counter to zero. A `tick` in the commit cycle of the clear is discarded.
- R7: Control bits 5 and 6 load flag 0 and flag 1 from the write data. Bits 7 and 8 return flag 0 and flag 1 on the read-data halves. When several read bits are committed together, the base (bit 2) wins over flag 0, and flag 0 wins over flag 1. The read data stays unchanged when no read bit is committed.
- R8: `cntRdCmd` high in a commit cycle arms a snapshot. The first cycle after that with `snapTrig` high copies the counter onto {`snapHi`,`snapLo`} and disarms it. `snapTrig` while disarmed leaves the snapshot unchanged.
- R9: A snapshot taken in a cycle that also has `tick` high captures the counter value from before that tick, in both halves.
- R10: The set-time sequence works as follows. Base load and counter clear are committed together, then flag 0 is loaded with 1. Afterwards `timeNow` equals the loaded base and a flag-0 read returns 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle seconds pulse |
| isoEn | input | 1 | Isolation-enable strobe; its rising edge commits commands |
| ctrlWord | input | 9 | Command bits (1 base load, 2 base read, 3 counter clear, 5/6 flag load, 7/8 flag read; 0 and 4 reserved) |
| cntRdCmd | input | 1 | Arms a counter snapshot when committed |
| snapTrig | input | 1 | Takes an armed snapshot |
| wrDataLo | input | WIDTH/2 | Low half of the write operand |
| wrDataHi | input | WIDTH/2 | High half of the write operand |
| rdDataLo | output | WIDTH/2 | Low half of the last read result |
| rdDataHi | output | WIDTH/2 | High half of the last read result |
| snapLo | output | WIDTH/2 | Low half of the counter snapshot |
| snapHi | output | WIDTH/2 | High half of the counter snapshot |
| timeNow | output | WIDTH | Base plus counter |

## Verification
Two functions can share a cycle. The first pair is a counter clear and a seconds tick. The bench raises `tick` in the same cycle that commits bit 3, and the counter must come out as zero, not one. The second pair is a snapshot and a tick. The bench pulses `snapTrig` on a tick cycle and expects the snapshot to hold the pre-tick count, while `timeNow` moves on by one. A base read and a base load can also share a commit cycle. In that case the read must return the old base. The bench runs with an 8-bit width, so it can sweep every base value and the full counter wrap arithmetically.

// File: rtl/rtc_epoch_pkg.sv
package rtc_epoch_pkg;
  localparam int NUM_FLAGS   = 2;
  localparam int CTRL_BITS   = 9;
  localparam int BIT_BASE_WR = 1;
  localparam int BIT_BASE_RD = 2;
  localparam int BIT_CNT_CLR = 3;
  localparam int BIT_FLAG_WR = 5;   // flag i load at BIT_FLAG_WR + i
  localparam int BIT_FLAG_RD = 7;   // flag i read at BIT_FLAG_RD + i

  typedef struct packed {
    logic                 ldBase;
    logic                 rdBase;
    logic                 clrCnt;
    logic [NUM_FLAGS-1:0] ldFlag;
    logic [NUM_FLAGS-1:0] rdFlag;
    logic                 takeSnap;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_epoch_ctrl.sv
module rtc_epoch_ctrl
  import rtc_epoch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isoEn,
  input  logic [CTRL_BITS-1:0] ctrlWord,
  input  logic                 cntRdCmd,
  input  logic                 snapTrig,
  output rtcStrobes_t          stb
);
  logic isoPrev;
  logic commit;
  logic armed;

  // A command window opens only on the low-to-high step of isoEn.
  assign commit = isoEn & ~isoPrev;

  always_ff @(posedge clk) begin
    if (!rstN) isoPrev <= 1'b0;
    else       isoPrev <= isoEn;
  end

  // Snapshot arming: a new arm in a commit cycle outranks disarming.
  always_ff @(posedge clk) begin
    if (!rstN)                    armed <= 1'b0;
    else if (commit && cntRdCmd)  armed <= 1'b1;
    else if (armed && snapTrig)   armed <= 1'b0;
  end

  assign stb.ldBase   = commit & ctrlWord[BIT_BASE_WR];
  assign stb.rdBase   = commit & ctrlWord[BIT_BASE_RD];
  assign stb.clrCnt   = commit & ctrlWord[BIT_CNT_CLR];
  assign stb.takeSnap = armed & snapTrig;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flagDecode
    assign stb.ldFlag[i] = commit & ctrlWord[BIT_FLAG_WR + i];
    assign stb.rdFlag[i] = commit & ctrlWord[BIT_FLAG_RD + i];
  end
endmodule

// File: rtl/rtc_epoch_dp.sv
module rtc_epoch_dp
  import rtc_epoch_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobes_t      stb,
  input  logic             tick,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] snapData,
  output logic [WIDTH-1:0] timeNow
);
  logic [WIDTH-1:0] baseReg;
  logic [WIDTH-1:0] cntReg;
  logic [WIDTH-1:0] flagReg [NUM_FLAGS];
  logic [WIDTH-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN)           baseReg <= '0;
    else if (stb.ldBase) baseReg <= wrData;
  end

  // Clear wins over a coincident tick; the counter wraps naturally.
  always_ff @(posedge clk) begin
    if (!rstN)           cntReg <= '0;
    else if (stb.clrCnt) cntReg <= '0;
    else if (tick)       cntReg <= cntReg + 1'b1;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)              flagReg[i] <= '0;
      else if (stb.ldFlag[i]) flagReg[i] <= wrData;
    end
  end

  // Read source priority: base, then lowest-numbered flag.
  always_comb begin
    rdNext = rdData;
    for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
      if (stb.rdFlag[i]) rdNext = flagReg[i];
    end
    if (stb.rdBase) rdNext = baseReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // Whole-word capture of the pre-tick count.
  always_ff @(posedge clk) begin
    if (!rstN)             snapData <= '0;
    else if (stb.takeSnap) snapData <= cntReg;
  end

  assign timeNow = baseReg + cntReg;
endmodule

// File: rtl/rtc_epoch_core.sv
module rtc_epoch_core
  import rtc_epoch_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 isoEn,
  input  logic [CTRL_BITS-1:0] ctrlWord,
  input  logic                 cntRdCmd,
  input  logic                 snapTrig,
  input  logic [WIDTH/2-1:0]   wrDataLo,
  input  logic [WIDTH/2-1:0]   wrDataHi,
  output logic [WIDTH/2-1:0]   rdDataLo,
  output logic [WIDTH/2-1:0]   rdDataHi,
  output logic [WIDTH/2-1:0]   snapLo,
  output logic [WIDTH/2-1:0]   snapHi,
  output logic [WIDTH-1:0]     timeNow
);
  localparam int HALF = WIDTH / 2;

  rtcStrobes_t      stb;
  logic [WIDTH-1:0] rdWord;
  logic [WIDTH-1:0] snapWord;

  rtc_epoch_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .isoEn    (isoEn),
    .ctrlWord (ctrlWord),
    .cntRdCmd (cntRdCmd),
    .snapTrig (snapTrig),
    .stb      (stb)
  );

  rtc_epoch_dp #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .tick     (tick),
    .wrData   ({wrDataHi, wrDataLo}),
    .rdData   (rdWord),
    .snapData (snapWord),
    .timeNow  (timeNow)
  );

  assign rdDataLo = rdWord[HALF-1:0];
  assign rdDataHi = rdWord[WIDTH-1:HALF];
  assign snapLo   = snapWord[HALF-1:0];
  assign snapHi   = snapWord[WIDTH-1:HALF];
endmodule

// File: rtl/rtc_epoch_chk.sv
module rtc_epoch_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               isoEn,
  input logic               ldBaseCmd,
  input logic               clrCmd,
  input logic               snapTrig,
  input logic [WIDTH/2-1:0] wrDataLo,
  input logic [WIDTH/2-1:0] wrDataHi,
  input logic [WIDTH/2-1:0] rdDataLo,
  input logic [WIDTH/2-1:0] rdDataHi,
  input logic [WIDTH/2-1:0] snapLo,
  input logic [WIDTH/2-1:0] snapHi,
  input logic [WIDTH-1:0]   timeNow
);
  logic seenLow;
  logic commitC;

  always_ff @(posedge clk) begin
    if (!rstN) seenLow <= 1'b0;
    else       seenLow <= isoEn;
  end
  assign commitC = isoEn && !seenLow;

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!commitC && tick) |=> timeNow == ($past(timeNow) + {{(WIDTH-1){1'b0}}, 1'b1})); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!commitC && !tick) |=> $stable(timeNow)); // R3

  AST_READ_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !commitC |=> ($stable(rdDataLo) && $stable(rdDataHi))); // R3

  AST_SET_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (commitC && ldBaseCmd && clrCmd) |=> timeNow == $past({wrDataHi, wrDataLo})); // R10

  AST_SNAP_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    !snapTrig |=> ($stable(snapLo) && $stable(snapHi))); // R8
endmodule

bind rtc_epoch_core rtc_epoch_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .isoEn     (isoEn),
  .ldBaseCmd (ctrlWord[1]),
  .clrCmd    (ctrlWord[3]),
  .snapTrig  (snapTrig),
  .wrDataLo  (wrDataLo),
  .wrDataHi  (wrDataHi),
  .rdDataLo  (rdDataLo),
  .rdDataHi  (rdDataHi),
  .snapLo    (snapLo),
  .snapHi    (snapHi),
  .timeNow   (timeNow)
);

// File: tb/rtc_epoch_core_tb_top.sv
module rtc_epoch_core_tb_top;
  localparam int W = 8;
  localparam int H = W / 2;
  // Command encodings from the requirements
  localparam logic [8:0] C_BWR = 9'(1 << 1);   // R4
  localparam logic [8:0] C_BRD = 9'(1 << 2);   // R5
  localparam logic [8:0] C_CLR = 9'(1 << 3);   // R6
  localparam logic [8:0] C_F0W = 9'(1 << 5);   // R7
  localparam logic [8:0] C_F1W = 9'(1 << 6);
  localparam logic [8:0] C_F0R = 9'(1 << 7);
  localparam logic [8:0] C_F1R = 9'(1 << 8);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, isoEn = 1'b0, cntRdCmd = 1'b0, snapTrig = 1'b0;
  logic [8:0] ctrlWord = '0;
  logic [H-1:0] wrDataLo = '0, wrDataHi = '0;
  logic [H-1:0] rdDataLo, rdDataHi, snapLo, snapHi;
  logic [W-1:0] timeNow;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [W-1:0] mBase = '0, mCnt = '0, mRd = '0, mSnap = '0;
  logic [W-1:0] mF0 = '0, mF1 = '0;
  logic mArm = 1'b0, mPrev = 1'b0;

  always #2.5 clk = ~clk;

  rtc_epoch_core #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .isoEn(isoEn), .ctrlWord(ctrlWord),
    .cntRdCmd(cntRdCmd), .snapTrig(snapTrig), .wrDataLo(wrDataLo), .wrDataHi(wrDataHi),
    .rdDataLo(rdDataLo), .rdDataHi(rdDataHi), .snapLo(snapLo), .snapHi(snapHi),
    .timeNow(timeNow)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " time"}, timeNow, mBase + mCnt);
    chk({tag, " rd"}, {rdDataHi, rdDataLo}, mRd);
    chk({tag, " snap"}, {snapHi, snapLo}, mSnap);
  endtask

  // One clock cycle of stimulus; the reference advances after the edge.
  task automatic cyc(input logic iso, input logic [8:0] c, input logic a,
                     input logic [W-1:0] d, input logic tk, input logic tg);
    logic commit;
    logic [W-1:0] oldBase, oldCnt;
    @(negedge clk);
    isoEn = iso; ctrlWord = c; cntRdCmd = a;
    {wrDataHi, wrDataLo} = d; tick = tk; snapTrig = tg;
    @(posedge clk);
    #1;
    commit = iso && !mPrev;
    oldBase = mBase; oldCnt = mCnt;
    if (commit) begin
      if (c[2])      mRd = oldBase;
      else if (c[7]) mRd = mF0;
      else if (c[8]) mRd = mF1;
    end
    if (mArm && tg) mSnap = oldCnt;
    if (commit && c[3]) mCnt = '0;
    else if (tk)        mCnt = oldCnt + 1'b1;
    if (commit && c[1]) mBase = d;
    if (commit && c[5]) mF0 = d;
    if (commit && c[6]) mF1 = d;
    if (commit && a)        mArm = 1'b1;
    else if (mArm && tg)    mArm = 1'b0;
    mPrev = iso;
  endtask

  task automatic win(input logic [8:0] c, input logic a, input logic [W-1:0] d,
                     input logic tk, input logic tg);
    cyc(1'b1, c, a, d, tk, tg);
    cyc(1'b0, '0, 1'b0, d, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: everything zero after reset, flags included
    checkAll("R1 reset");
    win(C_F0R, 1'b0, 8'hFF, 1'b0, 1'b0); checkAll("R1 flag0 zero");
    win(C_F1R, 1'b0, 8'hFF, 1'b0, 1'b0); checkAll("R1 flag1 zero");

    // R4/R5 sweep: load every base value with a same-window read (old base),
    // then read the new base back.
    for (int v = 0; v < (1 << W); v++) begin
      win(C_BWR | C_BRD, 1'b0, W'(v), 1'b0, 1'b0); checkAll("R5 read-before-load R4");
      win(C_BRD, 1'b0, '0, 1'b0, 1'b0);            checkAll("R5 read base");
    end

    // R2: clear, then full wrap of the counter
    win(C_CLR, 1'b0, '0, 1'b0, 1'b0); checkAll("R6 clear");
    for (int t = 0; t < (1 << W) + 3; t++) begin
      cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
      checkAll("R2 tick/wrap");
    end

    // R3: isoEn held high; only the first cycle commits
    cyc(1'b1, C_BWR, 1'b0, 8'h11, 1'b0, 1'b0); checkAll("R3 first commit");
    cyc(1'b1, C_BWR | C_BRD, 1'b0, 8'h22, 1'b0, 1'b0); checkAll("R3 held high ignored");
    cyc(1'b1, C_CLR | C_F0W, 1'b1, 8'h33, 1'b1, 1'b1); checkAll("R3 changed cmd ignored");
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    win(C_BRD, 1'b0, '0, 1'b0, 1'b0); checkAll("R3 base kept");

    // R6: clear with a coincident tick
    cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    win(C_CLR, 1'b0, '0, 1'b1, 1'b0); checkAll("R6 clear beats tick");

    // R7: flag loads, reads and read priority over all combinations
    win(C_F0W, 1'b0, 8'hA5, 1'b0, 1'b0);
    win(C_F1W, 1'b0, 8'h3C, 1'b0, 1'b0);
    for (int m = 0; m < 8; m++) begin
      win((m[0] ? C_BRD : 9'd0) | (m[1] ? C_F0R : 9'd0) | (m[2] ? C_F1R : 9'd0),
          1'b0, '0, 1'b0, 1'b0);
      checkAll("R7 read priority");
    end
    win(C_F0W | C_F1W, 1'b0, 8'h5A, 1'b0, 1'b0);
    win(C_F1R, 1'b0, '0, 1'b0, 1'b0); checkAll("R7 flag1 dual load");

    // R8: trigger without arm, armed trigger, repeat trigger
    cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b1); checkAll("R8 unarmed trig ignored");
    win('0, 1'b1, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b1); checkAll("R8 armed snapshot");
    cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b1); checkAll("R8 disarmed after use");

    // R9: snapshot coincident with a tick, over several counts
    for (int k = 0; k < 6; k++) begin
      win('0, 1'b1, '0, 1'b1, 1'b0);
      cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b1); checkAll("R9 pre-tick snapshot");
    end

    // R10: set-time sequence for several bases
    for (int b = 0; b < 256; b += 37) begin
      repeat (3) cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
      win(C_BWR | C_CLR, 1'b0, W'(b), 1'b1, 1'b0); checkAll("R10 base+clear");
      win(C_F0W, 1'b0, 8'h01, 1'b0, 1'b0);
      win(C_F0R, 1'b0, '0, 1'b0, 1'b0); checkAll("R10 valid flag");
      chk("R10 time equals base", timeNow, W'(b));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule